// File: doc/BRIEF.md
# Memory Request Sector Splitter

This block sits between a requester and a sector-organised memory stage. It takes one request at a time and turns it into one or more 32-byte sector requests. The input carries a base address, a size in bytes (32, 64 or 128), a four-bit sector mask, a byte mask that covers a full 128-byte line, and a write flag. Each output beat carries a child address, a one-hot sector mask, the part of the byte mask that belongs to that sector, and the write flag. Both sides use a valid/ready handshake.

A 32-byte request that names exactly one sector goes through unchanged as a single beat. A 128-byte request becomes four beats. A 64-byte request becomes two beats. For a 64-byte request the upper or lower half of the line is picked from the mask pattern. When the mask gives no answer, the address alignment decides. Any combination of size and mask that makes no sense is taken in and dropped, and a one-cycle error strobe reports it.

Top module: `sector_splitter`

## Requirements
- R1: After reset, outValid and errPulse are 0 and inReady is 1.
- R2: A request with inSize = 32 whose inSectMask has exactly one bit set gives one beat. That beat has outAddr = inAddr, outSectMask = inSectMask and outByteMask = the full inByteMask, unchanged.
- R3: A request with inSize = 128 gives beats for sectors 0, 1, 2 and 3, whatever its sector mask.
- R4: A request with inSize = 64 and inSectMask = 4'b1100 gives sectors 2 and 3. With inSectMask = 4'b0011 it gives sectors 0 and 1. Bit j of a sector mask stands for sector j.
- R5: A request with inSize = 64 and inSectMask of 4'b1111 or 4'b0000 gives sectors 0 and 1 when inAddr[6:0] is zero (128-byte aligned). Otherwise it gives sectors 2 and 3.
- R6: The k-th beat of a split request (k counted from 0) has outAddr = inAddr + 32*k. Its outSectMask has only bit j set, where j is the sector of that beat.
- R7: For a split request, the beat for sector j has outByteMask bits [32j+31:32j] equal to the input byte mask bits in that range, and all other bits 0.
- R8: Beats come out in ascending sector order, one per cycle while outReady is 1. While outReady is 0, outValid and all beat fields hold steady. inReady is 0 from the cycle after acceptance until the last beat has been accepted.
- R9: A request is an error in any of these cases: inSize is not 32, 64 or 128; inSize = 32 and the mask does not have exactly one bit set; inSize = 64 and the mask is not one of the four patterns above. An erroneous request is accepted, produces no beats, and raises errPulse for exactly the one cycle after acceptance.
- R10: outWrite on every beat equals the write flag of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Splitter can take a request |
| inAddr | input | 32 | Request base address |
| inSize | input | 8 | Request size in bytes |
| inSectMask | input | 4 | Request sector mask, bit j = sector j |
| inByteMask | input | 128 | Request byte mask, bit b = byte b of the line |
| inWrite | input | 1 | Request is a write |
| outValid | output | 1 | Sector beat present |
| outReady | input | 1 | Downstream takes the beat |
| outAddr | output | 32 | Beat address |
| outSectMask | output | 4 | One-hot sector of the beat |
| outByteMask | output | 128 | Byte mask for the beat |
| outWrite | output | 1 | Write flag of the beat |
| errPulse | output | 1 | One-cycle strobe for a dropped illegal request |

## Verification
The assertions assume that the input fields are stable only during the accepting cycle. The inputs are sampled once, and only when inValid and inReady are both high, so the bench changes them freely outside that cycle. The assertions also assume that outReady may drop at any time. The bench therefore stalls some beats in the middle of a split and checks that the held beat does not move. The stimulus covers every legal 64-byte mask pattern on both aligned and unaligned addresses, and it sends error requests back to back with legal ones. This confirms that a dropped request leaves no trace on the beat outputs.

// File: rtl/sector_split_pkg.sv
package sector_split_pkg;
  localparam int SECT_CNT   = 4;
  localparam int SECT_IDX_W = $clog2(SECT_CNT);

  typedef struct packed {
    logic load;   // capture an accepted legal request
    logic step;   // current beat taken downstream
  } splitStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } splitState_t;
endpackage

// File: rtl/split_decode.sv
module split_decode
  import sector_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 8,
  parameter int SECT_BYTES = 32
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [SIZE_W-1:0]     size,
  input  logic [SECT_CNT-1:0]   sectMask,
  output logic                  bad,
  output logic                  passThru,
  output logic [SECT_IDX_W-1:0] firstSect,
  output logic [SECT_IDX_W-1:0] lastSect
);
  localparam int LINE_BYTES = SECT_BYTES * SECT_CNT;
  localparam int HALF_BYTES = SECT_BYTES * 2;
  localparam int LINE_LSB   = $clog2(LINE_BYTES);

  localparam logic [SIZE_W-1:0]     SZ_ONE  = SIZE_W'(SECT_BYTES);
  localparam logic [SIZE_W-1:0]     SZ_HALF = SIZE_W'(HALF_BYTES);
  localparam logic [SIZE_W-1:0]     SZ_LINE = SIZE_W'(LINE_BYTES);
  localparam logic [SECT_CNT-1:0]   PAT_HI  = 4'b1100;
  localparam logic [SECT_CNT-1:0]   PAT_LO  = 4'b0011;
  localparam logic [SECT_CNT-1:0]   PAT_ALL = 4'b1111;
  localparam logic [SECT_CNT-1:0]   PAT_NON = 4'b0000;
  localparam logic [SECT_IDX_W-1:0] SEC_0   = SECT_IDX_W'(0);
  localparam logic [SECT_IDX_W-1:0] SEC_1   = SECT_IDX_W'(1);
  localparam logic [SECT_IDX_W-1:0] SEC_2   = SECT_IDX_W'(2);
  localparam logic [SECT_IDX_W-1:0] SEC_3   = SECT_IDX_W'(3);

  logic lineAligned;
  logic singleBit;

  assign lineAligned = (addr[LINE_LSB-1:0] == '0);
  assign singleBit   = ($countones(sectMask) == 1);

  always_comb begin
    bad       = 1'b0;
    passThru  = 1'b0;
    firstSect = SEC_0;
    lastSect  = SEC_0;
    if (size == SZ_ONE) begin
      passThru = 1'b1;
      bad      = !singleBit;
    end else if (size == SZ_LINE) begin
      firstSect = SEC_0;
      lastSect  = SEC_3;
    end else if (size == SZ_HALF) begin
      if (sectMask == PAT_HI) begin
        firstSect = SEC_2;
        lastSect  = SEC_3;
      end else if (sectMask == PAT_LO) begin
        firstSect = SEC_0;
        lastSect  = SEC_1;
      end else if (sectMask == PAT_ALL || sectMask == PAT_NON) begin
        firstSect = lineAligned ? SEC_0 : SEC_2;
        lastSect  = lineAligned ? SEC_1 : SEC_3;
      end else begin
        bad = 1'b1;
      end
    end else begin
      bad = 1'b1;
    end
  end

  // a legal split never runs backwards through the line
  always_comb begin
    if (!bad && !passThru) begin
      p_range_order_r4 : assert (firstSect <= lastSect);
    end
  end
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import sector_split_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  outReady,
  input  logic                  bad,
  input  logic                  passThru,
  input  logic [SECT_IDX_W-1:0] firstSect,
  input  logic [SECT_IDX_W-1:0] lastSect,
  output logic                  inReady,
  output logic                  outValid,
  output logic                  errPulse,
  output splitStrobe_t          strobe,
  output logic [SECT_IDX_W-1:0] curSect,
  output logic [SECT_IDX_W-1:0] childIdx,
  output logic                  passReg
);
  splitState_t           state;
  logic [SECT_IDX_W-1:0] lastReg;
  logic                  accept;
  logic                  lastBeat;

  assign inReady     = (state == ST_IDLE);
  assign outValid    = (state == ST_EMIT);
  assign accept      = inValid && inReady;
  assign strobe.load = accept && !bad;
  assign strobe.step = outValid && outReady;
  assign lastBeat    = strobe.step && (passReg || curSect == lastReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curSect  <= '0;
      lastReg  <= '0;
      childIdx <= '0;
      passReg  <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= accept && bad;
      if (strobe.load) begin
        state    <= ST_EMIT;
        curSect  <= firstSect;
        lastReg  <= lastSect;
        childIdx <= '0;
        passReg  <= passThru;
      end else if (strobe.step) begin
        if (lastBeat) begin
          state <= ST_IDLE;
        end else begin
          curSect  <= curSect + 1'b1;
          childIdx <= childIdx + 1'b1;
        end
      end
    end
  end

  p_stall_hold_r8 : assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(curSect) && $stable(childIdx));

  p_err_no_beat_r9 : assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !outValid);

  p_err_after_accept_r9 : assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(inValid && inReady));

  p_ascend_r8 : assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !passReg && curSect != lastReg
      |=> outValid && curSect == $past(curSect) + 1'b1);
endmodule

// File: rtl/split_datapath.sv
module split_datapath
  import sector_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SECT_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  splitStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]             inAddr,
  input  logic [SECT_CNT-1:0]           inSectMask,
  input  logic [SECT_CNT*SECT_BYTES-1:0] inByteMask,
  input  logic                          inWrite,
  input  logic [SECT_IDX_W-1:0]         curSect,
  input  logic [SECT_IDX_W-1:0]         childIdx,
  input  logic                          passThru,
  input  logic                          outValid,
  output logic [ADDR_W-1:0]             outAddr,
  output logic [SECT_CNT-1:0]           outSectMask,
  output logic [SECT_CNT*SECT_BYTES-1:0] outByteMask,
  output logic                          outWrite
);
  localparam int BM_W     = SECT_CNT * SECT_BYTES;
  localparam int SECT_LSB = $clog2(SECT_BYTES);

  logic [ADDR_W-1:0]   baseAddr;
  logic [SECT_CNT-1:0] keepMask;
  logic [BM_W-1:0]     byteMaskReg;
  logic                writeReg;
  logic [BM_W-1:0]     sectSlice [SECT_CNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr    <= '0;
      keepMask    <= '0;
      byteMaskReg <= '0;
      writeReg    <= 1'b0;
    end else if (strobe.load) begin
      baseAddr    <= inAddr;
      keepMask    <= inSectMask;
      byteMaskReg <= inByteMask;
      writeReg    <= inWrite;
    end
  end

  for (genvar g = 0; g < SECT_CNT; g++) begin : g_slice
    assign sectSlice[g] = byteMaskReg & (BM_W'({SECT_BYTES{1'b1}}) << (g * SECT_BYTES));
  end

  assign outAddr     = baseAddr + (ADDR_W'(childIdx) << SECT_LSB);
  assign outSectMask = passThru ? keepMask : (SECT_CNT'(1) << curSect);
  assign outByteMask = passThru ? byteMaskReg : sectSlice[curSect];
  assign outWrite    = writeReg;

  p_onehot_sector_r6 : assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $countones(outSectMask) == 1);

  p_first_addr_r6 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outAddr == baseAddr);

  p_write_kept_r10 : assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(outValid) |-> $stable(outWrite));
endmodule

// File: rtl/sector_splitter.sv
module sector_splitter
  import sector_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 8,
  parameter int SECT_BYTES = 32,
  localparam int BM_W      = SECT_CNT * SECT_BYTES
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic [SIZE_W-1:0]   inSize,
  input  logic [SECT_CNT-1:0] inSectMask,
  input  logic [BM_W-1:0]     inByteMask,
  input  logic                inWrite,
  output logic                outValid,
  input  logic                outReady,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [SECT_CNT-1:0] outSectMask,
  output logic [BM_W-1:0]     outByteMask,
  output logic                outWrite,
  output logic                errPulse
);
  logic                  bad;
  logic                  passThru;
  logic [SECT_IDX_W-1:0] firstSect;
  logic [SECT_IDX_W-1:0] lastSect;
  splitStrobe_t          strobe;
  logic [SECT_IDX_W-1:0] curSect;
  logic [SECT_IDX_W-1:0] childIdx;
  logic                  passReg;

  split_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SECT_BYTES(SECT_BYTES)
  ) u_decode (
    .addr(inAddr), .size(inSize), .sectMask(inSectMask),
    .bad(bad), .passThru(passThru), .firstSect(firstSect), .lastSect(lastSect)
  );

  split_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .bad(bad), .passThru(passThru), .firstSect(firstSect), .lastSect(lastSect),
    .inReady(inReady), .outValid(outValid), .errPulse(errPulse),
    .strobe(strobe), .curSect(curSect), .childIdx(childIdx), .passReg(passReg)
  );

  split_datapath #(
    .ADDR_W(ADDR_W), .SECT_BYTES(SECT_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inAddr(inAddr), .inSectMask(inSectMask), .inByteMask(inByteMask),
    .inWrite(inWrite), .curSect(curSect), .childIdx(childIdx),
    .passThru(passReg), .outValid(outValid),
    .outAddr(outAddr), .outSectMask(outSectMask),
    .outByteMask(outByteMask), .outWrite(outWrite)
  );
endmodule

// File: tb/sector_splitter_bench.sv
module sector_splitter_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  size;
    logic [3:0]  mask;
    logic [31:0] addr;
    logic        wr;
    logic        err;
    logic [1:0]  first;
    logic [1:0]  last;
    logic [31:0] seed;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{8'd32,  4'b0001, 32'h0000_1000, 1'b0, 1'b0, 2'd0, 2'd0, 32'h1111_0001},
    '{8'd32,  4'b0100, 32'h0000_2040, 1'b1, 1'b0, 2'd2, 2'd2, 32'h2222_0002},
    '{8'd128, 4'b1111, 32'h0000_3000, 1'b1, 1'b0, 2'd0, 2'd3, 32'h3333_0003},
    '{8'd64,  4'b1100, 32'h0000_4040, 1'b0, 1'b0, 2'd2, 2'd3, 32'h4444_0004},
    '{8'd64,  4'b0011, 32'h0000_5000, 1'b1, 1'b0, 2'd0, 2'd1, 32'h5555_0005},
    '{8'd64,  4'b1111, 32'h0000_6000, 1'b0, 1'b0, 2'd0, 2'd1, 32'h6666_0006},
    '{8'd64,  4'b0000, 32'h0000_6040, 1'b1, 1'b0, 2'd2, 2'd3, 32'h7777_0007},
    '{8'd32,  4'b0011, 32'h0000_7000, 1'b0, 1'b1, 2'd0, 2'd0, 32'h8888_0008},
    '{8'd64,  4'b1111, 32'h0000_6020, 1'b0, 1'b0, 2'd2, 2'd3, 32'h9999_0009},
    '{8'd32,  4'b0000, 32'h0000_7020, 1'b0, 1'b1, 2'd0, 2'd0, 32'hAAAA_000A},
    '{8'd64,  4'b0000, 32'h0000_7000, 1'b0, 1'b0, 2'd0, 2'd1, 32'hBBBB_000B},
    '{8'd64,  4'b0110, 32'h0000_8000, 1'b1, 1'b1, 2'd0, 2'd0, 32'hCCCC_000C},
    '{8'd96,  4'b1111, 32'h0000_9000, 1'b0, 1'b1, 2'd0, 2'd0, 32'hDDDD_000D},
    '{8'd16,  4'b0001, 32'h0000_A000, 1'b0, 1'b1, 2'd0, 2'd0, 32'hEEEE_000E},
    '{8'd64,  4'b1000, 32'h0000_B000, 1'b1, 1'b1, 2'd0, 2'd0, 32'hFFFF_000F}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [31:0]  inAddr = '0;
  logic [7:0]   inSize = '0;
  logic [3:0]   inSectMask = '0;
  logic [127:0] inByteMask = '0;
  logic         inWrite = 1'b0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [31:0]  outAddr;
  logic [3:0]   outSectMask;
  logic [127:0] outByteMask;
  logic         outWrite;
  logic         errPulse;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_splitter u_sector_splitter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inSize(inSize), .inSectMask(inSectMask),
    .inByteMask(inByteMask), .inWrite(inWrite), .outValid(outValid),
    .outReady(outReady), .outAddr(outAddr), .outSectMask(outSectMask),
    .outByteMask(outByteMask), .outWrite(outWrite), .errPulse(errPulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkMask(input logic [31:0] seed);
    return {seed + 32'h3030_0303, seed + 32'h2020_0202, seed + 32'h1010_0101, seed};
  endfunction

  function automatic string reqOf(input vec_t v);
    if (v.err) return "R9";
    if (v.size == 8'd32) return "R2";
    if (v.size == 8'd128) return "R3";
    if (v.mask == 4'b1100 || v.mask == 4'b0011) return "R4";
    return "R5";
  endfunction

  // drive one request; returns at the negedge after acceptance
  task automatic sendReq(input vec_t v);
    @(negedge clk);
    chk(inReady == 1'b1, "R8", "inReady idle", 128'(inReady), 128'd1);
    inValid    = 1'b1;
    inAddr     = v.addr;
    inSize     = v.size;
    inSectMask = v.mask;
    inByteMask = mkMask(v.seed);
    inWrite    = v.wr;
    @(negedge clk);
    inValid    = 1'b0;
    inAddr     = 32'hDEAD_BEEF;
    inSectMask = 4'b0101;
    inByteMask = '1;
    inWrite    = ~v.wr;
  endtask

  task automatic runVec(input vec_t v, input int stallBeat);
    string tag = reqOf(v);
    logic [127:0] bm = mkMask(v.seed);
    sendReq(v);
    if (v.err) begin
      chk(errPulse == 1'b1, "R9", "errPulse raised", 128'(errPulse), 128'd1);
      chk(outValid == 1'b0, "R9", "no beat on error", 128'(outValid), 128'd0);
      @(negedge clk);
      chk(errPulse == 1'b0, "R9", "errPulse one cycle", 128'(errPulse), 128'd0);
      chk(outValid == 1'b0, "R9", "still no beat", 128'(outValid), 128'd0);
      return;
    end
    chk(errPulse == 1'b0, tag, "no error on legal", 128'(errPulse), 128'd0);
    if (v.size == 8'd32) begin
      chk(outValid == 1'b1, "R2", "pass beat valid", 128'(outValid), 128'd1);
      chk(outAddr == v.addr, "R2", "pass addr", 128'(outAddr), 128'(v.addr));
      chk(outSectMask == v.mask, "R2", "pass sector mask", 128'(outSectMask), 128'(v.mask));
      chk(outByteMask == bm, "R2", "pass byte mask", outByteMask, bm);
      chk(outWrite == v.wr, "R10", "pass write", 128'(outWrite), 128'(v.wr));
      @(negedge clk);
    end else begin
      for (int k = 0; k <= int'(v.last) - int'(v.first); k++) begin
        int j = int'(v.first) + k;
        logic [31:0]  eAddr = v.addr + 32'(32 * k);
        logic [3:0]   eSect = 4'(1) << j;
        logic [127:0] eBm   = bm & (128'hFFFF_FFFF << (32 * j));
        if (k == stallBeat) begin
          outReady = 1'b0;
          for (int s = 0; s < 3; s++) begin
            chk(outValid == 1'b1 && outAddr == eAddr && outSectMask == eSect
                && outByteMask == eBm, "R8", "stalled beat held",
                128'(outAddr), 128'(eAddr));
            @(negedge clk);
          end
          outReady = 1'b1;
        end
        chk(outValid == 1'b1, "R8", "beat valid", 128'(outValid), 128'd1);
        chk(inReady == 1'b0, "R8", "inReady low while busy", 128'(inReady), 128'd0);
        chk(outAddr == eAddr, "R6", "child addr", 128'(outAddr), 128'(eAddr));
        chk(outSectMask == eSect, tag, "child sector", 128'(outSectMask), 128'(eSect));
        chk(outByteMask == eBm, "R7", "child byte mask", outByteMask, eBm);
        chk(outWrite == v.wr, "R10", "child write", 128'(outWrite), 128'(v.wr));
        @(negedge clk);
      end
    end
    chk(outValid == 1'b0, "R8", "no extra beat", 128'(outValid), 128'd0);
    chk(inReady == 1'b1, "R8", "ready after last", 128'(inReady), 128'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", "outValid in reset", 128'(outValid), 128'd0);
    chk(errPulse == 1'b0, "R1", "errPulse in reset", 128'(errPulse), 128'd0);
    chk(inReady == 1'b1, "R1", "inReady in reset", 128'(inReady), 128'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && inReady == 1'b1, "R1", "idle after reset",
        128'({outValid, inReady}), 128'b01);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], -1);

    // R8: stalls inside a split, including on the first and last beats
    runVec(VECS[2], 0);
    runVec(VECS[2], 2);
    runVec(VECS[3], 1);
    // R9 then R3 back to back: dropped request leaves no trace
    runVec(VECS[12], -1);
    runVec(VECS[2], 3);
    // R5 boundary: address 0x80 is line aligned
    runVec('{8'd64, 4'b1111, 32'h0000_0080, 1'b1, 1'b0, 2'd0, 2'd1, 32'h0BAD_F00D}, -1);
    // R5 boundary: address 0x01 is not aligned
    runVec('{8'd64, 4'b0000, 32'h0000_0001, 1'b0, 1'b0, 2'd2, 2'd3, 32'h1234_5678}, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule